// File: doc/BRIEF.md
# Model-Specific Register Read Unit

This block carries out a processor's read of a 64-bit model-specific register. The operation uses the two-byte opcode 0F 32 and has no explicit operands. Its inputs arrive already decoded: the 64-bit count register, which holds the register address, the current privilege level, the operating mode and whether a lock prefix was present. The unit first checks whether the operation is allowed. If it is, the unit looks the address up in a small table of implemented registers. It then either writes the selected value into two 64-bit destinations or reports one exception, never both. The high destination receives the upper word of the register and the low destination receives the lower word. In both destinations bits 63:32 are cleared.

The register table is set by parameters: a 32-bit address, a mask of implemented bits and a reset value for each entry. A test-write port lets the entries be reloaded at run time. Bits an entry does not implement always read as zero, so results can be checked exactly. The operation changes no status flags, and the block has no flag output.

A state machine with three states orders the responses. `ST_IDLE` means no response is due. `ST_DONE` presents a successful read. `ST_FAULT` presents an exception. From any state, an accepted request moves the machine to `ST_DONE` (transition *grant*) or to `ST_FAULT` (transition *refuse*). A cycle with no request returns it to `ST_IDLE` (transition *drain*). Requests can therefore arrive back to back.

Top module: `msr_read_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `rsp_wr_en` and `rsp_exc` are all zero.
- R2: Only bits 31:0 of `req_addr` select the register. The value of bits 63:32 does not change the result.
- R3: On a successful read, `rsp_hi[31:0]` equals bits 63:32 of the register and `rsp_lo[31:0]` equals bits 31:0. Bits 63:32 of both `rsp_hi` and `rsp_lo` are zero.
- R4: Bits that are clear in an entry's implemented-bit mask read as zero.
- R5: A request with `req_lock` = 1 reports the invalid-opcode exception (`rsp_exc` = 2'b01) in every mode. This check takes priority over all the others.
- R6: If there is no lock prefix, a request in virtual-8086 mode (`req_mode` = 2) always reports the general-protection exception (`rsp_exc` = 2'b10).
- R7: If there is no lock prefix, a request in protected (1), compatibility (3) or 64-bit (4) mode with `req_cpl` not equal to 0 reports the general-protection exception.
- R8: An address not in the table reports the general-protection exception in every mode, real-address mode (0) included.
- R9: Each accepted request produces exactly one response, one cycle later, with exactly one of `rsp_wr_en` or `rsp_exc` set. A cycle with no request produces no response.
- R10: When an exception is reported, `rsp_wr_en` is 0 and both destinations read zero. The exception's error code is always 0.
- R11: A test write to entry index `tw_idx` changes that entry's value, and the new value is visible to the next read.
- R12: In real-address mode the privilege level is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Count register value; only bits 31:0 are used as the address |
| req_cpl | input | 2 | Current privilege level |
| req_mode | input | 3 | 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| req_lock | input | 1 | Lock prefix present |
| tw_en | input | 1 | Test-write strobe |
| tw_idx | input | 2 | Table entry to write |
| tw_data | input | 64 | Value to write |
| rsp_valid | output | 1 | Response present |
| rsp_wr_en | output | 1 | Write both destinations |
| rsp_hi | output | 64 | High destination value |
| rsp_lo | output | 64 | Low destination value |
| rsp_exc | output | 2 | One-hot exception: bit 0 invalid opcode, bit 1 general protection |
| rsp_err_code | output | 16 | Error code of the exception, always 0 |

## Verification
Every response, including its exception bits, is due one rising edge after the request is sampled. The bench drives each request on a falling edge and reads the outputs on the next falling edge, when that single register stage has just updated. A test write takes effect on the edge that samples it, so a read issued on the following falling edge already sees the new value. Idle cycles are checked on the falling edge after a cycle with no request, where no response may appear.

// File: rtl/msr_rd_pkg.sv
package msr_rd_pkg;

    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_PROT   = 3'd1,
        MODE_V86    = 3'd2,
        MODE_COMPAT = 3'd3,
        MODE_LONG   = 3'd4
    } cpu_mode_e;

    localparam int EXC_W = 2;
    localparam logic [EXC_W-1:0] EXC_NONE = 2'b00;
    localparam logic [EXC_W-1:0] EXC_UD   = 2'b01;
    localparam logic [EXC_W-1:0] EXC_GP   = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } rd_state_e;

endpackage

// File: rtl/msr_reg_table.sv
module msr_reg_table #(
    parameter int N_REGS = 4,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2,
    parameter logic [N_REGS*ADDR_W-1:0] REG_ADDRS = '0,
    parameter logic [N_REGS*DATA_W-1:0] REG_MASKS = '0,
    parameter logic [N_REGS*DATA_W-1:0] REG_INIT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_idx,
    input  logic [DATA_W-1:0] tw_data,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              lookup_hit,
    output logic [DATA_W-1:0] lookup_data
);

    logic [N_REGS-1:0] hit_vec;
    logic [DATA_W-1:0] sel_vec [N_REGS];

    for (genvar i = 0; i < N_REGS; i++) begin : g_ent
        logic [DATA_W-1:0] store_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q <= REG_INIT[i*DATA_W +: DATA_W];
            end else if (tw_en && (tw_idx == IDX_W'(i))) begin
                store_q <= tw_data;
            end
        end

        assign hit_vec[i] = (lookup_addr == REG_ADDRS[i*ADDR_W +: ADDR_W]);
        assign sel_vec[i] = hit_vec[i] ? (store_q & REG_MASKS[i*DATA_W +: DATA_W])
                                       : '0;
    end

    always_comb begin
        lookup_data = '0;
        for (int k = 0; k < N_REGS; k++) begin
            lookup_data = lookup_data | sel_vec[k];
        end
    end

    assign lookup_hit = |hit_vec;

endmodule

// File: rtl/msr_fault_gate.sv
module msr_fault_gate
    import msr_rd_pkg::*;
(
    input  logic             lock,
    input  cpu_mode_e        mode,
    input  logic [1:0]       cpl,
    input  logic             hit,
    output logic [EXC_W-1:0] exc
);

    always_comb begin
        if (lock) begin
            exc = EXC_UD;
        end else if (mode == MODE_V86) begin
            exc = EXC_GP;
        end else if ((mode != MODE_REAL) && (cpl != 2'd0)) begin
            exc = EXC_GP;
        end else if (!hit) begin
            exc = EXC_GP;
        end else begin
            exc = EXC_NONE;
        end
    end

endmodule

// File: rtl/msr_read_unit.sv
module msr_read_unit
    import msr_rd_pkg::*;
#(
    parameter int N_REGS = 4,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1,
    parameter logic [N_REGS*ADDR_W-1:0] REG_ADDRS =
        {32'hC000_0080, 32'h0000_0277, 32'h0000_01A0, 32'h0000_0010},
    parameter logic [N_REGS*DATA_W-1:0] REG_MASKS =
        {64'h0000_0000_0000_0D01, 64'h0707_0707_0707_0707,
         64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    parameter logic [N_REGS*DATA_W-1:0] REG_INIT =
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
         64'hFFFF_FFFF_0000_1234, 64'h0123_4567_89AB_CDEF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic [1:0]        req_cpl,
    input  logic [2:0]        req_mode,
    input  logic              req_lock,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_idx,
    input  logic [DATA_W-1:0] tw_data,
    output logic              rsp_valid,
    output logic              rsp_wr_en,
    output logic [63:0]       rsp_hi,
    output logic [63:0]       rsp_lo,
    output logic [1:0]        rsp_exc,
    output logic [15:0]       rsp_err_code
);

    localparam int HALF_W = DATA_W / 2;

    rd_state_e         st_q, st_d;
    logic              tbl_hit;
    logic [DATA_W-1:0] tbl_data;
    logic [EXC_W-1:0]  gate_exc;
    logic [63:0]       hi_q, lo_q;
    logic [EXC_W-1:0]  exc_q;

    msr_reg_table #(
        .N_REGS    (N_REGS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .REG_ADDRS (REG_ADDRS),
        .REG_MASKS (REG_MASKS),
        .REG_INIT  (REG_INIT)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .tw_en       (tw_en),
        .tw_idx      (tw_idx),
        .tw_data     (tw_data),
        .lookup_addr (req_addr[ADDR_W-1:0]),
        .lookup_hit  (tbl_hit),
        .lookup_data (tbl_data)
    );

    msr_fault_gate u_gate (
        .lock (req_lock),
        .mode (cpu_mode_e'(req_mode)),
        .cpl  (req_cpl),
        .hit  (tbl_hit),
        .exc  (gate_exc)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (!req_valid) begin
                    st_d = ST_IDLE;
                end else if (gate_exc == EXC_NONE) begin
                    st_d = ST_DONE;
                end else begin
                    st_d = ST_FAULT;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            exc_q <= EXC_NONE;
        end else begin
            unique case (st_d)
                ST_DONE: begin
                    hi_q  <= {32'd0, 32'(tbl_data[DATA_W-1:HALF_W])};
                    lo_q  <= {32'd0, 32'(tbl_data[HALF_W-1:0])};
                    exc_q <= EXC_NONE;
                end
                ST_FAULT: begin
                    hi_q  <= '0;
                    lo_q  <= '0;
                    exc_q <= gate_exc;
                end
                default: begin
                    hi_q  <= '0;
                    lo_q  <= '0;
                    exc_q <= EXC_NONE;
                end
            endcase
        end
    end

    assign rsp_valid    = (st_q != ST_IDLE);
    assign rsp_wr_en    = (st_q == ST_DONE);
    assign rsp_hi       = hi_q;
    assign rsp_lo       = lo_q;
    assign rsp_exc      = exc_q;
    assign rsp_err_code = 16'd0;

endmodule

// File: rtl/msr_read_unit_chk.sv
module msr_read_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_cpl,
    input logic [2:0]  req_mode,
    input logic        req_lock,
    input logic        rsp_valid,
    input logic        rsp_wr_en,
    input logic [63:0] rsp_hi,
    input logic [63:0] rsp_lo,
    input logic [1:0]  rsp_exc
);

    assert_req_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_wr_en, rsp_exc}) == 1));

    assert_exc_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_exc));

    assert_lock_ud_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lock) |=> (rsp_exc == 2'b01));

    assert_v86_gp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lock && req_mode == 3'd2) |=> (rsp_exc == 2'b10));

    assert_cpl_gp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lock && req_mode != 3'd0 && req_mode != 3'd2
         && req_cpl != 2'd0) |=> (rsp_exc == 2'b10));

    assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en |-> (rsp_hi[63:32] == 32'd0 && rsp_lo[63:32] == 32'd0));

    assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc != 2'b00) |-> (!rsp_wr_en && rsp_hi == 64'd0 && rsp_lo == 64'd0));

endmodule

bind msr_read_unit msr_read_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cpl   (req_cpl),
    .req_mode  (req_mode),
    .req_lock  (req_lock),
    .rsp_valid (rsp_valid),
    .rsp_wr_en (rsp_wr_en),
    .rsp_hi    (rsp_hi),
    .rsp_lo    (rsp_lo),
    .rsp_exc   (rsp_exc)
);

// File: tb/msr_read_unit_test.sv
`timescale 1ns/1ps
module msr_read_unit_test;

    localparam logic [127:0] ADDRS =
        {32'hC000_0080, 32'h0000_0277, 32'h0000_01A0, 32'h0000_0010};
    localparam logic [255:0] MASKS =
        {64'h0000_0000_0000_0D01, 64'h0707_0707_0707_0707,
         64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [255:0] INITS =
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
         64'hFFFF_FFFF_0000_1234, 64'h0123_4567_89AB_CDEF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_cpl = '0;
    logic [2:0]  req_mode = '0;
    logic        req_lock = 1'b0;
    logic        tw_en = 1'b0;
    logic [1:0]  tw_idx = '0;
    logic [63:0] tw_data = '0;
    logic        rsp_valid, rsp_wr_en;
    logic [63:0] rsp_hi, rsp_lo;
    logic [1:0]  rsp_exc;
    logic [15:0] rsp_err_code;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] model [4];

    always #2 clk = ~clk;

    msr_read_unit #(
        .N_REGS(4), .REG_ADDRS(ADDRS), .REG_MASKS(MASKS), .REG_INIT(INITS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cpl(req_cpl), .req_mode(req_mode), .req_lock(req_lock),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
        .rsp_valid(rsp_valid), .rsp_wr_en(rsp_wr_en), .rsp_hi(rsp_hi),
        .rsp_lo(rsp_lo), .rsp_exc(rsp_exc), .rsp_err_code(rsp_err_code)
    );

    task automatic check(input string tag, input logic [199:0] act, input logic [199:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [63:0] addr, input logic [1:0] cpl,
                          input logic [2:0] mode, input logic lock);
        logic [1:0]  e_exc;
        logic [63:0] e_hi, e_lo, val;
        logic        hit;
        string       tag;
        hit = 1'b0;
        val = '0;
        for (int i = 0; i < 4; i++) begin
            if (addr[31:0] == ADDRS[i*32 +: 32]) begin
                hit = 1'b1;
                val = model[i] & MASKS[i*64 +: 64];
            end
        end
        e_hi = '0;
        e_lo = '0;
        if (lock) begin
            e_exc = 2'b01; tag = "R5";
        end else if (mode == 3'd2) begin
            e_exc = 2'b10; tag = "R6";
        end else if (mode != 3'd0 && cpl != 2'd0) begin
            e_exc = 2'b10; tag = "R7";
        end else if (!hit) begin
            e_exc = 2'b10; tag = "R8";
        end else begin
            e_exc = 2'b00;
            e_hi = {32'd0, val[63:32]};
            e_lo = {32'd0, val[31:0]};
            tag = (mode == 3'd0 && cpl != 0) ? "R12/R3/R4/R2" : "R3/R4/R2";
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_cpl = cpl; req_mode = mode; req_lock = lock;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 R10 response"},
              {54'd0, rsp_valid, rsp_wr_en, rsp_exc, rsp_err_code, rsp_hi, rsp_lo},
              {54'd0, 1'b1, (e_exc == 2'b00), e_exc, 16'd0, e_hi, e_lo});
    endtask

    task automatic sweep();
        logic [63:0] addrs [10];
        for (int i = 0; i < 4; i++) begin
            addrs[i]   = {32'h0, ADDRS[i*32 +: 32]};
            addrs[i+4] = {32'hDEAD_BEEF, ADDRS[i*32 +: 32]};
        end
        addrs[8] = 64'h0000_0000_0000_0011;
        addrs[9] = 64'h0000_0000_FFFF_FFFF;
        for (int m = 0; m < 5; m++)
            for (int c = 0; c < 4; c++)
                for (int l = 0; l < 2; l++)
                    for (int a = 0; a < 10; a++)
                        do_req(addrs[a], 2'(c), 3'(m), l[0]);
    endtask

    initial begin
        #800000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = INITS[i*64 +: 64];
        repeat (3) @(negedge clk);
        check("R1 during reset", {196'd0, rsp_valid, rsp_wr_en, rsp_exc},
              200'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {196'd0, rsp_valid, rsp_wr_en, rsp_exc}, 200'd0);
        @(negedge clk);
        check("R9 idle no response", {199'd0, rsp_valid}, 200'd0);
        sweep();
        @(negedge clk);
        check("R9 idle after sweep", {199'd0, rsp_valid}, 200'd0);
        // R11: reload every entry through the test-write port
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            tw_en = 1'b1;
            tw_idx = 2'(i);
            tw_data = 64'hA5C3_0F96_5A3C_F069 ^ {16{4'(i)}};
            model[i] = tw_data;
        end
        @(negedge clk);
        tw_en = 1'b0;
        do_req(64'h0000_0000_0000_0010, 2'd0, 3'd4, 1'b0); // R11
        sweep();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule